// File: doc/BRIEF.md
# Dual-Path Synthesizer Register Loader

This block is the host-facing register front end of a direct digital synthesis modulator. A host can stage a 32-bit word in two ways. The first is a byte- or halfword-wide parallel bus, gated by an active-low select and captured on the falling edge of an active-low write strobe. The second is a two-wire serial link that clocks one data bit in on each rising edge of a serial clock, most significant bit first. Each path fills its own staging (assembly) register. Both paths may be in use at the same moment.

A 4-bit transfer code and a LOAD strobe then copy one staging register into a single destination. The destinations are the command register, two frequency words, a phase word and an amplitude (IQ) word. LOAD and the serial clock are sampled in the system clock domain through synchronizers. The block exposes only the destination register contents. The downstream synthesis datapath reads them directly.

Top module: `dds_reg_loader`

## Requirements
- R1: While `rst` is high on a rising `clk` edge, every destination output reads zero. Both staging registers are cleared. The command register reads 0, which selects the 8-bit parallel width.
- R2: On each falling edge of `wr_n` with `cs_n` low, the parallel staging register shifts left and takes the bus data into its low bits. With command bit 0 = 0 the shift is 8 bits and only `pdata[7:0]` enters. With bit 0 = 1 the shift is 16 bits and all of `pdata` enters. A falling edge with `cs_n` high leaves the register unchanged.
- R3: Each high pulse of `sclk`, with `sdata` held steady, shifts `sdata` into bit 0 of the serial staging register while older bits move up, so 32 pulses place the first bit at bit 31. Each pulse must last at least three `clk` periods and be followed by a low time of at least three periods. A register that is not shifted keeps its value.
- R4: Parallel-source codes are 1000 for command, 1001 for frequency 0, 1010 for frequency 1, 1011 for phase and 1100 for IQ.
- R5: Serial-source codes are 1101 for frequency 1, 1110 for frequency 0, 1111 for phase and 0000 for IQ. No code loads the command register from the serial path.
- R6: Codes 0001 through 0111 change no destination register.
- R7: Each LOAD pulse performs exactly one transfer, however long it stays high. The destination takes its new value on the third rising `clk` edge counted from the first edge that sees LOAD high. A destination changes only on such a transfer or on reset.
- R8: A command transfer keeps only the low 4 bits of the parallel staging register. Bit 0 then selects the parallel width for later writes.
- R9: A transfer does not clear its source staging register. If a transfer and a serial shift fall on the same `clk` edge, the transfer copies the pre-shift serial value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (also clears the parallel staging register at once) |
| pdata | input | 16 | Parallel data bus |
| cs_n | input | 1 | Active-low chip select for parallel writes |
| wr_n | input | 1 | Active-low write strobe, data captured on its falling edge |
| sclk | input | 1 | Serial bit clock |
| sdata | input | 1 | Serial data bit |
| tc | input | 4 | Transfer code: source and destination |
| load | input | 1 | Transfer strobe, sampled by `clk` |
| cmd_q | output | 4 | Command register |
| freq0_q | output | 32 | Frequency word 0 |
| freq1_q | output | 32 | Frequency word 1 |
| phase_q | output | 32 | Phase word |
| iq_q | output | 32 | IQ amplitude word |

## Verification
A serial bit shift and a LOAD transfer can land on the same system clock edge. The bench provokes this by raising `sclk` and LOAD in the same cycle with a serial-source code selected. It then judges that the destination holds the staging value from before that bit, while the staging register still gains the bit. The bench also runs parallel writes and serial shifting concurrently, and it strobes a parallel write while a long LOAD pulse is high. In that case the destination must keep the value captured at the pulse's single transfer.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;

   localparam int NUM_DEST = 5;
   localparam int NUM_WORD = 4;
   localparam int DST_CMD  = 0;
   localparam int DST_F0   = 1;
   localparam int DST_F1   = 2;
   localparam int DST_PH   = 3;
   localparam int DST_IQ   = 4;

   typedef enum logic {SRC_PAR = 1'b0, SRC_SER = 1'b1} src_e;

   typedef struct packed {
      logic       hit;
      src_e       src;
      logic [2:0] dest;
   } xfer_t;

   function automatic xfer_t decode_tc(input logic [3:0] code);
      xfer_t r;
      r = '{hit: 1'b1, src: SRC_PAR, dest: 3'(DST_CMD)};
      unique case (code)
         4'b1000: r.dest = 3'(DST_CMD);
         4'b1001: r.dest = 3'(DST_F0);
         4'b1010: r.dest = 3'(DST_F1);
         4'b1011: r.dest = 3'(DST_PH);
         4'b1100: r.dest = 3'(DST_IQ);
         4'b1101: begin r.src = SRC_SER; r.dest = 3'(DST_F1); end
         4'b1110: begin r.src = SRC_SER; r.dest = 3'(DST_F0); end
         4'b1111: begin r.src = SRC_SER; r.dest = 3'(DST_PH); end
         4'b0000: begin r.src = SRC_SER; r.dest = 3'(DST_IQ); end
         default: r.hit = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dds_sync.sv
module dds_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dds_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("dds_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dds_load_edge.sv
module dds_load_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   output logic fire
);
   logic level, level_d;

   dds_sync #(.STAGES(STAGES), .W(1)) u_sync (
      .clk(clk), .rst(rst), .d(load), .q(level)
   );

   always_ff @(posedge clk) begin
      if (rst) level_d <= 1'b0;
      else     level_d <= level;
   end

   assign fire = level & ~level_d;

   a_r7_single_fire: assert property (@(posedge clk) disable iff (rst)
      fire |=> !fire)
      else $error("a_r7_single_fire");
endmodule

// File: rtl/dds_par_asm.sv
module dds_par_asm #(
   parameter int WORD_W   = 32,
   parameter int BUS_W    = 16,
   parameter int NARROW_W = 8
) (
   input  logic              rst,
   input  logic              wr_n,
   input  logic              cs_n,
   input  logic              wide,
   input  logic [BUS_W-1:0]  pdata,
   output logic [WORD_W-1:0] par_q
);
   if (WORD_W % BUS_W != 0 || WORD_W % NARROW_W != 0) begin : g_bad_div
      $error("dds_par_asm: bus widths must divide WORD_W");
   end
   if (NARROW_W > BUS_W || BUS_W >= WORD_W) begin : g_bad_order
      $error("dds_par_asm: need NARROW_W <= BUS_W < WORD_W");
   end

   always_ff @(negedge wr_n or posedge rst) begin
      if (rst) begin
         par_q <= '0;
      end else if (!cs_n) begin
         if (wide) par_q <= {par_q[WORD_W-BUS_W-1:0], pdata};
         else      par_q <= {par_q[WORD_W-NARROW_W-1:0], pdata[NARROW_W-1:0]};
      end
   end
endmodule

// File: rtl/dds_ser_asm.sv
module dds_ser_asm #(
   parameter int WORD_W = 32,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk,
   input  logic              sdata,
   output logic [WORD_W-1:0] ser_q
);
   logic [1:0] synced;
   logic       sclk_d;
   logic       shift;

   dds_sync #(.STAGES(STAGES), .W(2)) u_sync (
      .clk(clk), .rst(rst), .d({sclk, sdata}), .q(synced)
   );

   always_ff @(posedge clk) begin
      if (rst) sclk_d <= 1'b0;
      else     sclk_d <= synced[1];
   end

   assign shift = synced[1] & ~sclk_d;

   always_ff @(posedge clk) begin
      if (rst)        ser_q <= '0;
      else if (shift) ser_q <= {ser_q[WORD_W-2:0], synced[0]};
   end

   a_r3_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
      !shift |=> $stable(ser_q))
      else $error("a_r3_hold_without_edge");
endmodule

// File: rtl/dds_dest_bank.sv
module dds_dest_bank
   import dds_loader_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CMD_W  = 4
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NUM_DEST-1:0]              wen,
   input  logic [WORD_W-1:0]                src_word,
   output logic [CMD_W-1:0]                 cmd_o,
   output logic [NUM_WORD-1:0][WORD_W-1:0]  word_o
);
   if (CMD_W < 1 || CMD_W > WORD_W) begin : g_bad_cmd
      $error("dds_dest_bank: CMD_W out of range");
   end

   always_ff @(posedge clk) begin
      if (rst)               cmd_o <= '0;
      else if (wen[DST_CMD]) cmd_o <= src_word[CMD_W-1:0];
   end

   for (genvar i = 0; i < NUM_WORD; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)           word_o[i] <= '0;
         else if (wen[i+1]) word_o[i] <= src_word;
      end
   end

   a_r6_onehot_wen: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wen))
      else $error("a_r6_onehot_wen");
endmodule

// File: rtl/dds_reg_loader.sv
module dds_reg_loader
   import dds_loader_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int BUS_W    = 16,
   parameter int NARROW_W = 8,
   parameter int CMD_W    = 4,
   parameter int STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BUS_W-1:0]  pdata,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              sclk,
   input  logic              sdata,
   input  logic [3:0]        tc,
   input  logic              load,
   output logic [CMD_W-1:0]  cmd_q,
   output logic [WORD_W-1:0] freq0_q,
   output logic [WORD_W-1:0] freq1_q,
   output logic [WORD_W-1:0] phase_q,
   output logic [WORD_W-1:0] iq_q
);
   logic [WORD_W-1:0]                par_q, ser_q, src_word;
   logic                             fire;
   xfer_t                            dec;
   logic [NUM_DEST-1:0]              wen;
   logic [NUM_WORD-1:0][WORD_W-1:0]  words;

   dds_par_asm #(.WORD_W(WORD_W), .BUS_W(BUS_W), .NARROW_W(NARROW_W)) u_par (
      .rst(rst), .wr_n(wr_n), .cs_n(cs_n), .wide(cmd_q[0]),
      .pdata(pdata), .par_q(par_q)
   );

   dds_ser_asm #(.WORD_W(WORD_W), .STAGES(STAGES)) u_ser (
      .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .ser_q(ser_q)
   );

   dds_load_edge #(.STAGES(STAGES)) u_load (
      .clk(clk), .rst(rst), .load(load), .fire(fire)
   );

   always_comb begin
      dec      = decode_tc(tc);
      src_word = (dec.src == SRC_SER) ? ser_q : par_q;
      wen      = '0;
      if (fire && dec.hit) wen[dec.dest] = 1'b1;
   end

   dds_dest_bank #(.WORD_W(WORD_W), .CMD_W(CMD_W)) u_bank (
      .clk(clk), .rst(rst), .wen(wen), .src_word(src_word),
      .cmd_o(cmd_q), .word_o(words)
   );

   assign freq0_q = words[DST_F0-1];
   assign freq1_q = words[DST_F1-1];
   assign phase_q = words[DST_PH-1];
   assign iq_q    = words[DST_IQ-1];

   a_r7_quiet_without_load: assert property (@(posedge clk) disable iff (rst)
      !fire |=> ($stable(cmd_q) && $stable(freq0_q) && $stable(freq1_q)
                 && $stable(phase_q) && $stable(iq_q)))
      else $error("a_r7_quiet_without_load");

   a_r5_cmd_par_only: assert property (@(posedge clk) disable iff (rst)
      (fire && dec.src == SRC_SER) |=> $stable(cmd_q))
      else $error("a_r5_cmd_par_only");

   a_r6_bad_code_idle: assert property (@(posedge clk) disable iff (rst)
      (fire && !dec.hit) |=> ($stable(cmd_q) && $stable(freq0_q)
                 && $stable(freq1_q) && $stable(phase_q) && $stable(iq_q)))
      else $error("a_r6_bad_code_idle");
endmodule

// File: tb/tb_dds_reg_loader.sv
module tb_dds_reg_loader;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] pdata = '0;
   logic        cs_n = 1'b1, wr_n = 1'b1, sclk = 1'b0, sdata = 1'b0, load = 1'b0;
   logic [3:0]  tc = 4'b0101;
   logic [3:0]  cmd_q;
   logic [31:0] freq0_q, freq1_q, phase_q, iq_q;

   logic [31:0] m_par = '0, m_ser = '0, m_f0 = '0, m_f1 = '0, m_ph = '0, m_iq = '0;
   logic [3:0]  m_cmd = '0;
   int          errs = 0, checks = 0;
   bit          chk_on = 0, done = 0;
   string       cur_req = "R1";

   always #4 clk = ~clk;

   dds_reg_loader dut (
      .clk(clk), .rst(rst), .pdata(pdata), .cs_n(cs_n), .wr_n(wr_n),
      .sclk(sclk), .sdata(sdata), .tc(tc), .load(load), .cmd_q(cmd_q),
      .freq0_q(freq0_q), .freq1_q(freq1_q), .phase_q(phase_q), .iq_q(iq_q)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // reference model compared on every clock, away from the edge
   always @(negedge clk) if (chk_on && !done) begin
      check(cur_req, "cmd",   {28'd0, cmd_q}, {28'd0, m_cmd});
      check(cur_req, "freq0", freq0_q, m_f0);
      check(cur_req, "freq1", freq1_q, m_f1);
      check(cur_req, "phase", phase_q, m_ph);
      check(cur_req, "iq",    iq_q,    m_iq);
   end

   function automatic void model_xfer(input logic [3:0] code);
      case (code)
         4'b1000: m_cmd = m_par[3:0];
         4'b1001: m_f0 = m_par;
         4'b1010: m_f1 = m_par;
         4'b1011: m_ph = m_par;
         4'b1100: m_iq = m_par;
         4'b1101: m_f1 = m_ser;
         4'b1110: m_f0 = m_ser;
         4'b1111: m_ph = m_ser;
         4'b0000: m_iq = m_ser;
         default: ;
      endcase
   endfunction

   task automatic pwrite(input logic [15:0] d, input logic sel_n);
      @(negedge clk);
      #1 pdata = d; cs_n = sel_n;
      #1 wr_n = 1'b0;
      #1 if (!sel_n) m_par = m_cmd[0] ? {m_par[15:0], d} : {m_par[23:0], d[7:0]};
      #2 wr_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic sbit(input logic b);
      @(negedge clk);
      sdata = b; sclk = 1'b1;
      repeat (3) @(posedge clk);
      #1 m_ser = {m_ser[30:0], b};
      @(negedge clk) sclk = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   task automatic sword(input logic [31:0] w);
      for (int i = 31; i >= 0; i--) sbit(w[i]);
   endtask

   task automatic pload(input logic [3:0] code, input int hold);
      @(negedge clk);
      tc = code; load = 1'b1;
      repeat (3) @(posedge clk);
      #1 model_xfer(code);
      repeat (hold - 2) @(negedge clk);
      load = 1'b0;
      repeat (4) @(posedge clk);
   endtask

   // serial bit and transfer reach the same clk edge (R9)
   task automatic sbit_with_load(input logic b, input logic [3:0] code);
      @(negedge clk);
      sdata = b; sclk = 1'b1; tc = code; load = 1'b1;
      repeat (3) @(posedge clk);
      #1 model_xfer(code);
      m_ser = {m_ser[30:0], b};
      @(negedge clk) sclk = 1'b0; load = 1'b0;
      repeat (4) @(posedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errs++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      @(posedge clk);
      chk_on = 1;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R2 R4: 8-bit mode, upper bus bits ignored, code 1001
      cur_req = "R2";
      pwrite(16'hAB12, 1'b0); pwrite(16'hCD34, 1'b0);
      pwrite(16'hEF56, 1'b0); pwrite(16'h0178, 1'b0);
      cur_req = "R4";
      pload(4'b1001, 3);
      check("R4", "freq0 literal", freq0_q, 32'h12345678);

      // R2 ignored write, R9 source kept after transfer
      cur_req = "R2";
      pwrite(16'h00AA, 1'b1);
      pload(4'b1010, 3);
      check("R2", "cs_n high ignored", freq1_q, 32'h12345678);
      check("R9", "source kept", freq0_q, freq1_q);

      // R8: command from low 4 bits, selects 16-bit width
      cur_req = "R8";
      pwrite(16'h00F1, 1'b0);
      pload(4'b1000, 3);
      check("R8", "cmd low bits", {28'd0, cmd_q}, 32'h1);
      pwrite(16'hDEAD, 1'b0); pwrite(16'hBEEF, 1'b0);
      cur_req = "R4";
      pload(4'b1011, 3);
      pload(4'b1100, 3);
      check("R8", "16-bit writes", phase_q, 32'hDEADBEEF);
      check("R4", "iq from parallel", iq_q, 32'hDEADBEEF);

      // R3 R5: serial word, all serial codes
      cur_req = "R3";
      sword(32'hA5C30F96);
      cur_req = "R5";
      pload(4'b1101, 3);
      check("R5", "1101 to freq1", freq1_q, 32'hA5C30F96);
      check("R5", "cmd untouched", {28'd0, cmd_q}, 32'h1);
      cur_req = "R3";
      fork
         sword(32'h3C5A9617);
         begin pwrite(16'h1357, 1'b0); pwrite(16'h9BDF, 1'b0); end
      join
      cur_req = "R5";
      pload(4'b1110, 3);
      pload(4'b1111, 3);
      pload(4'b0000, 3);
      check("R3", "serial after concurrent use", freq0_q, 32'h3C5A9617);
      check("R5", "iq from serial", iq_q, 32'h3C5A9617);
      cur_req = "R4";
      pload(4'b1001, 3);
      check("R4", "parallel during serial", freq0_q, 32'h13579BDF);

      // R6: unused codes move nothing
      cur_req = "R6";
      for (int c = 1; c <= 7; c++) pload(4'(c), 3);
      check("R6", "freq1 after idle codes", freq1_q, 32'hA5C30F96);

      // R7: long pulse, one transfer, write during high time
      cur_req = "R7";
      fork
         pload(4'b1001, 12);
         begin repeat (6) @(negedge clk); pwrite(16'h2468, 1'b0); end
      join
      check("R7", "single transfer", freq0_q, 32'h13579BDF);
      pload(4'b1001, 3);
      check("R7", "next pulse transfers", freq0_q, 32'h9BDF2468);

      // R9: serial shift and transfer on the same edge
      cur_req = "R9";
      sword(32'h0000FFFF);
      sbit_with_load(1'b1, 4'b1101);
      check("R9", "pre-shift value", freq1_q, 32'h0000FFFF);
      pload(4'b1110, 3);
      check("R9", "bit still shifted", freq0_q, 32'h0001FFFF);

      // R1: reset mid-run
      cur_req = "R1";
      @(negedge clk) rst = 1'b1;
      m_par = '0; m_ser = '0;
      @(posedge clk);
      #1 m_cmd = '0; m_f0 = '0; m_f1 = '0; m_ph = '0; m_iq = '0;
      @(negedge clk);
      check("R1", "freq0 cleared", freq0_q, 32'h0);
      check("R1", "cmd cleared", {28'd0, cmd_q}, 32'h0);
      rst = 1'b0;
      pwrite(16'h77C1, 1'b0);
      pload(4'b1001, 3);
      check("R1", "staging cleared, 8-bit mode", freq0_q, 32'h000000C1);

      repeat (4) @(posedge clk);
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule